// File: doc/BRIEF.md
# Match-Driven Debug Trigger Sequencer

This block is a small trigger state machine for on-chip debug. Once armed it waits in a first stage and watches three comparator match pulses. A 4-bit selector, held in a byte-wide control register, picks the rule that decides which stage comes next. The stages are a second stage, a third stage, or the terminal "final" stage. When the sequencer reaches the final stage it emits a one-cycle trigger pulse. It then holds there until software disarms it.

Software reaches the control register through a simple read/write port. Access is gated by a 2-bit bank select. A write is also refused while the sequencer is armed, so the rule cannot change in the middle of a sequence. Each match channel takes part only when its comparator enable input is set. The second and third stages follow a fixed policy: any enabled match advances to the final stage.

Top module: `trig_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `trig_o` is 0, and the selector reads back as 0. The `state_o` encoding is: 0 idle, 1 first stage, 2 second stage, 3 third stage, 4 final.
- R2: When `rd_i` is high, `addr_i` is 0x27 and `bank_i` is 00, `rdata_o` equals the selector in bits 3:0 with bits 7:4 at zero. For any other bank or address, or with `rd_i` low, `rdata_o` is 0.
- R3: A write with `wr_i` high, `addr_i` 0x27 and `bank_i` 00 stores `wdata_i[3:0]` as the selector. The write is ignored while `state_o` is not idle, and it is ignored for any other bank or address.
- R4: `arm_i` in the idle state moves the sequencer to the first stage on the next clock; `arm_i` in any other state has no effect. `disarm_i` returns the sequencer to idle on the next clock from any state and takes priority over `arm_i` and over every match.
- R5: In the first stage, a single enabled match moves the sequencer according to the selector:
  - 0: any channel goes to final.
  - 1: channel 1 goes to the third stage.
  - 2: channel 2 goes to the second stage.
  - 3: channel 1 goes to the second stage.
  - 4: channel 0 goes to the second stage; channel 1 goes to the third stage.
  - 5: channel 0 goes to final; channel 1 goes to the third stage.
  - 6: channel 0 goes to the second stage; channel 2 goes to the third stage.
  - 7: channel 0 or channel 1 goes to the second stage.
  - 9: channel 0 goes to the third stage.
  - 13: channel 0 or channel 2 goes to final; channel 1 goes to the second stage.
- R6: In the first stage, the selector values 8, 10, 11, 12, 14 and 15 cause no transition. A match on a channel that the selected rule does not list also leaves the sequencer in the first stage.
- R7: When several effective matches arrive in one cycle, a match that leads to final wins. If none does, the lowest-numbered channel wins. For example, selector 13 with channels 0 and 1 together goes to final.
- R8: A match on a channel whose `cmp_en_i` bit is 0 is ignored in every stage.
- R9: From the second or third stage, any enabled match moves the sequencer to final. Final holds until `disarm_i`.
- R10: `trig_o` is high for exactly the one cycle in which `state_o` first shows final after some other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | 2 | Register bank select; 00 exposes the control register |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational) |
| arm_i | input | 1 | Arm request |
| disarm_i | input | 1 | Disarm request |
| match_i | input | 3 | Comparator match pulses, one per channel |
| cmp_en_i | input | 3 | Comparator enables, one per channel |
| state_o | output | 3 | Current stage (encoding in R1) |
| trig_o | output | 1 | One-cycle pulse on entry to final |

## Verification
The interesting collisions are between matches on different channels in the same cycle, and between a disarm and a match or arm in the same cycle. The bench steps through every selector value with all seven non-empty match patterns, all three channels enabled. This covers single matches and every simultaneous pair and triple. A behavioural model decides the winner by the final-first, then lowest-channel rule. Disarm is also raised together with arm and with matches, and the model expects idle on the next clock. A register write during an armed sequence is attempted and must be refused.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_st_e;

  // per-channel target out of stage one; ST_ONE means "no effect"
  function automatic seq_st_e sel_target(input logic [SEL_W-1:0] sel, input int ch);
    seq_st_e t;
    t = ST_ONE;
    case (sel)
      4'd0:  t = ST_FINAL;
      4'd1:  if (ch == 1) t = ST_THREE;
      4'd2:  if (ch == 2) t = ST_TWO;
      4'd3:  if (ch == 1) t = ST_TWO;
      4'd4:  if (ch == 0) t = ST_TWO; else if (ch == 1) t = ST_THREE;
      4'd5:  if (ch == 0) t = ST_FINAL; else if (ch == 1) t = ST_THREE;
      4'd6:  if (ch == 0) t = ST_TWO; else if (ch == 2) t = ST_THREE;
      4'd7:  if (ch != 2) t = ST_TWO;
      4'd9:  if (ch == 0) t = ST_THREE;
      4'd13: if (ch == 1) t = ST_TWO; else t = ST_FINAL;
      default: t = ST_ONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/trig_sel_decode.sv
module trig_sel_decode
  import trig_seq_pkg::*;
#(
  parameter int unsigned CH = NUM_CH,
  parameter int unsigned SW = SEL_W
) (
  input  logic [SW-1:0] sel_i,
  input  logic [CH-1:0] hit_i,
  output logic          go_o,
  output seq_st_e       next_o
);
  seq_st_e tgt [CH];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign tgt[c] = sel_target(sel_i, c);
  end

  always_comb begin
    go_o   = 1'b0;
    next_o = ST_ONE;
    // lowest channel assigned last so it wins
    for (int c = CH - 1; c >= 0; c--) begin
      if (hit_i[c] && tgt[c] != ST_ONE) begin
        go_o   = 1'b1;
        next_o = tgt[c];
      end
    end
    // a final target overrides any channel order
    for (int c = 0; c < CH; c++) begin
      if (hit_i[c] && tgt[c] == ST_FINAL) next_o = ST_FINAL;
    end
  end
endmodule

// File: rtl/trig_seq_regs.sv
module trig_seq_regs #(
  parameter int unsigned        AW       = 8,
  parameter int unsigned        DW       = 8,
  parameter int unsigned        BW       = 2,
  parameter int unsigned        SW       = 4,
  parameter logic [AW-1:0]      REG_ADDR = 8'h27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          armed_i,
  output logic [DW-1:0] rdata_o,
  output logic [SW-1:0] sel_o
);
  localparam int unsigned PAD_W = DW - SW;

  logic          hit;
  logic [SW-1:0] sel_q;

  assign hit = (bank_i == '0) && (addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sel_q <= '0;
    else if (wr_i && hit && !armed_i) sel_q <= wdata_i[SW-1:0];
  end

  assign rdata_o = (rd_i && hit) ? {{PAD_W{1'b0}}, sel_q} : '0;
  assign sel_o   = sel_q;

  AST_WR_LOCKED_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(sel_q)); // R3
  AST_WR_LOCKED_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i != '0) |=> $stable(sel_q)); // R3
  AST_RD_OFF_BANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i != '0) |-> (rdata_o == '0)); // R2
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int unsigned CH = NUM_CH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          disarm_i,
  input  logic [CH-1:0] hit_i,
  input  logic          go_i,
  input  seq_st_e       dec_next_i,
  output seq_st_e       state_o,
  output logic          trig_o
);
  seq_st_e state_q, state_d;
  logic    trig_q;

  always_comb begin
    state_d = state_q;
    if (disarm_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  if (arm_i) state_d = ST_ONE;
        ST_ONE:   if (go_i) state_d = dec_next_i;
        ST_TWO, ST_THREE: if (|hit_i) state_d = ST_FINAL;
        ST_FINAL: state_d = ST_FINAL;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= (state_d == ST_FINAL) && (state_q != ST_FINAL);
    end
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;

  AST_DISARM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> (state_q == ST_IDLE)); // R4
  AST_FINAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINAL && !disarm_i) |=> (state_q == ST_FINAL)); // R9
  AST_ONE_HOLD_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONE && !disarm_i && hit_i == '0) |=> (state_q == ST_ONE)); // R6
  AST_TRIG_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> (state_q == ST_FINAL && $past(state_q) != ST_FINAL)); // R10
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q); // R10
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int unsigned        AW       = 8,
  parameter int unsigned        DW       = 8,
  parameter int unsigned        BW       = 2,
  parameter logic [AW-1:0]      REG_ADDR = 8'h27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BW-1:0]     bank_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [NUM_CH-1:0] match_i,
  input  logic [NUM_CH-1:0] cmp_en_i,
  output logic [2:0]        state_o,
  output logic              trig_o
);
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] hits;
  logic              go;
  seq_st_e           dec_next, state;

  assign hits = match_i & cmp_en_i;

  trig_seq_regs #(
    .AW(AW), .DW(DW), .BW(BW), .SW(SEL_W), .REG_ADDR(REG_ADDR)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bank_i  (bank_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rd_i    (rd_i),
    .armed_i (state != ST_IDLE),
    .rdata_o (rdata_o),
    .sel_o   (sel)
  );

  trig_sel_decode #(.CH(NUM_CH), .SW(SEL_W)) u_dec (
    .sel_i  (sel),
    .hit_i  (hits),
    .go_o   (go),
    .next_o (dec_next)
  );

  trig_seq_fsm #(.CH(NUM_CH)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .disarm_i   (disarm_i),
    .hit_i      (hits),
    .go_i       (go),
    .dec_next_i (dec_next),
    .state_o    (state),
    .trig_o     (trig_o)
  );

  assign state_o = state;

  AST_PRIO_FINAL_SEL13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ONE && !disarm_i && sel == 4'd13 && hits[0] && hits[1])
    |=> (state == ST_FINAL)); // R7
  AST_DISABLED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && !disarm_i && cmp_en_i == '0) |=> $stable(state)); // R8
endmodule

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank = '0;
  logic [7:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       arm = 1'b0;
  logic       disarm = 1'b0;
  logic [2:0] match = '0;
  logic [2:0] en = 3'b111;
  logic [2:0] state;
  logic       trig;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_st = 0;
  int m_sel = 0;
  bit m_trig = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_i(bank), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .arm_i(arm), .disarm_i(disarm),
    .match_i(match), .cmp_en_i(en), .state_o(state), .trig_o(trig)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model: target for one channel under a selector, 1 = no effect
  function automatic int tgt(int s, int ch);
    if (s == 0) return 4;
    if (s == 1 && ch == 1) return 3;
    if (s == 2 && ch == 2) return 2;
    if (s == 3 && ch == 1) return 2;
    if (s == 4) return (ch == 0) ? 2 : (ch == 1) ? 3 : 1;
    if (s == 5) return (ch == 0) ? 4 : (ch == 1) ? 3 : 1;
    if (s == 6) return (ch == 0) ? 2 : (ch == 2) ? 3 : 1;
    if (s == 7 && ch < 2) return 2;
    if (s == 9 && ch == 0) return 3;
    if (s == 13) return (ch == 1) ? 2 : 4;
    return 1;
  endfunction

  function automatic int stage_one_next(int s, logic [2:0] h);
    int best = 1;
    for (int c = 0; c < 3; c++) if (h[c] && tgt(s, c) == 4) return 4;
    for (int c = 2; c >= 0; c--) if (h[c] && tgt(s, c) != 1) best = tgt(s, c);
    return best;
  endfunction

  task automatic step(string tag);
    int exp_rd;
    int nxt;
    logic [2:0] h;
    #1;
    exp_rd = (rd && addr == 8'h27 && bank == 2'b00) ? m_sel : 0;
    check(rdata == 8'(exp_rd), {tag, " rdata"}, rdata, exp_rd);
    @(posedge clk);
    h = match & en;
    nxt = m_st;
    if (disarm) nxt = 0;
    else case (m_st)
      0: if (arm) nxt = 1;
      1: nxt = stage_one_next(m_sel, h);
      2, 3: if (h != 0) nxt = 4;
      default: nxt = m_st;
    endcase
    if (wr && addr == 8'h27 && bank == 2'b00 && m_st == 0) m_sel = int'(wdata[3:0]);
    m_trig = (nxt == 4 && m_st != 4);
    m_st = nxt;
    @(negedge clk);
    check(int'(state) == m_st, {tag, " state"}, state, m_st);
    check(trig == m_trig, {tag, " trig"}, trig, m_trig);
  endtask

  task automatic idle_inputs();
    wr = 0; rd = 0; arm = 0; disarm = 0; match = '0; bank = '0; addr = '0;
  endtask

  task automatic write_sel(int v, logic [1:0] b, string tag);
    idle_inputs(); bank = b; addr = 8'h27; wr = 1; wdata = 8'(v);
    step(tag);
    idle_inputs();
  endtask

  task automatic read_sel(logic [1:0] b, logic [7:0] a, string tag);
    idle_inputs(); bank = b; addr = a; rd = 1;
    step(tag);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2;
    check(state == 3'd0, "R1 reset state", state, 0);
    check(trig == 1'b0, "R1 reset trig", trig, 0);
    rd = 1; addr = 8'h27; #1;
    check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    rd = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step("R1 idle");

    write_sel(8'hF5, 2'b00, "R3 write");
    read_sel(2'b00, 8'h27, "R2 readback");
    read_sel(2'b01, 8'h27, "R2 other bank");
    read_sel(2'b00, 8'h26, "R2 other addr");
    write_sel(8'h03, 2'b10, "R3 wrong bank");
    write_sel(8'h03, 2'b00, "R3 wrong addr pre");
    idle_inputs(); addr = 8'h28; wr = 1; wdata = 8'h07; step("R3 wrong addr"); idle_inputs();
    read_sel(2'b00, 8'h27, "R3 readback");

    arm = 1; step("R4 arm");
    idle_inputs();
    write_sel(8'h09, 2'b00, "R3 write while armed");
    read_sel(2'b00, 8'h27, "R3 armed readback");
    disarm = 1; arm = 1; step("R4 disarm beats arm"); idle_inputs();

    // sweep every selector and match pattern
    for (int s = 0; s < 16; s++) begin
      for (int p = 1; p < 8; p++) begin
        write_sel(s, 2'b00, "R3 sweep write");
        arm = 1; step("R4 sweep arm"); idle_inputs();
        match = 3'(p);
        if (s == 8 || s == 10 || s == 11 || s == 12 || s == 14 || s == 15)
          step("R6 reserved");
        else if (p == 1 || p == 2 || p == 4) step("R5 single match");
        else step("R7 simultaneous");
        match = '0; step("R9 hold");
        match = 3'b111; step("R9 second stage to final");
        match = 3'b001; arm = 1; step("R9 final sticky / R4 arm ignored");
        idle_inputs(); disarm = 1; step("R4 disarm"); idle_inputs();
      end
    end

    // explicit priority case: selector 13, channels 0 and 1
    write_sel(13, 2'b00, "R7 set 13");
    arm = 1; step("R7 arm"); idle_inputs();
    match = 3'b011; step("R7 final wins");
    check(state == 3'd4, "R7 sel13 state", state, 4);
    idle_inputs(); disarm = 1; step("R4 disarm"); idle_inputs();

    // enables
    write_sel(0, 2'b00, "R8 set 0");
    arm = 1; step("R8 arm"); idle_inputs();
    en = 3'b000; match = 3'b111; step("R8 all disabled");
    en = 3'b011; match = 3'b100; step("R8 ch2 disabled");
    en = 3'b100; match = 3'b100; step("R8 ch2 enabled");
    check(trig == 1'b1, "R10 trig pulse", trig, 1);
    match = '0; step("R10 trig clears");
    en = 3'b111;
    disarm = 1; step("R4 disarm"); idle_inputs();

    // disabled channel in second stage; disarm with match
    write_sel(3, 2'b00, "R8 set 3");
    arm = 1; step("R8 arm"); idle_inputs();
    match = 3'b010; step("R5 to second");
    en = 3'b101; match = 3'b010; step("R8 stage2 disabled");
    en = 3'b111; match = 3'b111; disarm = 1; step("R4 disarm beats match");
    idle_inputs(); step("R4 idle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule